// File: doc/BRIEF.md
# Busy-Indicator ADC Readout Controller

This block is the host side of a serial analog-to-digital converter link that runs with four wires: convert, select, serial clock and serial data. A start request makes the controller raise the select line, then raise the convert strobe while select is still high. The converter treats that edge as a conversion start in chip-select mode. The controller then lowers select, keeps convert high, and watches the shared data line. A pull-up holds that line high while the converter is not driving it.

When the converter finishes, it drives the data line low. The controller passes the line through a small synchronizer and takes that falling level as its end-of-conversion event. It then produces a divided serial clock that idles low and gives nineteen pulses. It shifts in the 18-bit result MSB first on the rising edges, publishes the word on a parallel output with a one-cycle valid strobe, and drops convert one cycle later. If the data line never falls, a timeout raises an error flag and the controller abandons the conversion.

Top module: `adc_busy_reader`

## Requirements
- R1: After reset, convOut, selOut, sckOut, dataValid, busy and timeoutErr are all 0.
- R2: A start accepted in idle raises selOut at the next clock edge. convOut rises SEL_SETUP cycles later, and selOut is still high in that cycle.
- R3: selOut falls exactly SEL_HOLD cycles after convOut rises (SEL_HOLD is below MIN_CONV). It stays low for the rest of the conversion and the readout.
- R4: convOut stays high from its rise through the whole readout and the valid cycle. It falls in the cycle right after the dataValid pulse.
- R5: sckOut stays low while the synchronized sdoIn remains high (1 = converter busy or not driving). A low level on sdoIn means conversion complete, and the readout starts only after it.
- R6: During a readout sckOut gives exactly WORD_BITS+1 pulses. Each high phase and each low phase lasts max(clkDivHalf,1) clock cycles. sckOut is low whenever no readout runs.
- R7: Pulse 1's rising edge discards the busy-low level. Rising edges 2 to WORD_BITS+1 sample sdoIn as the result, MSB first, so dataWord[WORD_BITS-1] is the first bit captured.
- R8: dataValid is a single-cycle pulse. dataWord changes only with that pulse and holds its value until the next one.
- R9: If sdoIn has not gone low by MAX_CONV+timeoutLimit cycles after convOut rose, timeoutErr is set and convOut and busy drop in that cycle. There are no sckOut pulses and no dataValid. The next start clears timeoutErr.
- R10: busy is high from the cycle selOut rises until convOut falls. startReq is ignored while busy, so it starts no second conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request a conversion (sampled while idle) |
| clkDivHalf | input | DIV_W | Serial clock half period in system cycles (0 acts as 1) |
| timeoutLimit | input | TO_W | Extra cycles allowed after the maximum conversion time |
| sdoIn | input | 1 | Serial data from the converter (pulled high when released) |
| convOut | output | 1 | Convert strobe to the converter |
| selOut | output | 1 | Select line to the converter |
| sckOut | output | 1 | Serial clock to the converter |
| dataWord | output | WORD_BITS | Last captured result |
| dataValid | output | 1 | One-cycle strobe when dataWord is updated |
| busy | output | 1 | Conversion or readout in progress |
| timeoutErr | output | 1 | End of conversion never signalled on the last attempt |

## Verification
The bench checks the select and convert edges to the exact cycle. A controller that raised convert with select low would start the converter in the wrong mode, and one that held select too long would hide the busy indication. The converter model holds the data line high for a long time, so a design that clocked too early would show serial clock pulses before end of conversion. All-ones and single-one words, together with a count of the clock pulses, catch an off-by-one in bit capture: a design that kept the busy-low bit or dropped the last data bit returns a shifted word. A converter that never answers tests the timeout one cycle before and at the deadline, and a start pulse sent during a conversion must not begin a second one.

// File: rtl/adc_busy_pkg.sv
`timescale 1ns/1ps
package adc_busy_pkg;

  // Controller phases.
  typedef enum logic [2:0] {
    S_IDLE,
    S_SELSETUP,
    S_CONVSEL,
    S_CONVWAIT,
    S_READ,
    S_DONE,
    S_RELEASE
  } ctrlState_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic clearRead; // reset the serial engine for a new conversion
    logic runSck;    // let the serial clock generator run
    logic publish;   // copy the shift register to the output word
  } dpCtrl_t;

endpackage

// File: rtl/adc_busy_ctrl.sv
`timescale 1ns/1ps
module adc_busy_ctrl
  import adc_busy_pkg::*;
#(
  parameter int TO_W      = 16,
  parameter int SEL_SETUP = 2,
  parameter int SEL_HOLD  = 4,
  parameter int MIN_CONV  = 20,
  parameter int MAX_CONV  = 40
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic [TO_W-1:0] timeoutLimit,
  input  logic            sdoLow,
  input  logic            readDone,
  output logic            convOut,
  output logic            selOut,
  output logic            busyOut,
  output logic            timeoutErr,
  output dpCtrl_t         dpCtl
);

  localparam int CNT_W = TO_W + $clog2(MAX_CONV + 1) + 1;

  ctrlState_t state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limitSum;
  logic convReg;
  logic selReg;
  logic errReg;

  assign limitSum = CNT_W'(MAX_CONV) + CNT_W'(timeoutLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      convReg <= 1'b0;
      selReg  <= 1'b0;
      errReg  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (startReq) begin
            state  <= S_SELSETUP;
            selReg <= 1'b1;
            errReg <= 1'b0;
            cnt    <= '0;
          end
        end
        S_SELSETUP: begin
          if (cnt == CNT_W'(SEL_SETUP - 1)) begin
            state   <= S_CONVSEL;
            convReg <= 1'b1;
            cnt     <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_CONVSEL: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(SEL_HOLD - 1)) begin
            selReg <= 1'b0;
            state  <= S_CONVWAIT;
          end
        end
        S_CONVWAIT: begin
          cnt <= cnt + 1'b1;
          if (sdoLow) begin
            state <= S_READ;
          end else if (cnt >= limitSum) begin
            errReg  <= 1'b1;
            convReg <= 1'b0;
            state   <= S_IDLE;
          end
        end
        S_READ: begin
          if (readDone) state <= S_DONE;
        end
        S_DONE: begin
          state <= S_RELEASE;
        end
        S_RELEASE: begin
          convReg <= 1'b0;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtl.clearRead = (state == S_IDLE) && startReq;
    dpCtl.runSck    = (state == S_READ);
    dpCtl.publish   = (state == S_DONE);
  end

  assign convOut    = convReg;
  assign selOut     = selReg;
  assign busyOut    = (state != S_IDLE);
  assign timeoutErr = errReg;

  // R2: convert must rise while select is high.
  assert_conv_rise_with_sel_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convReg) |-> selReg);

  // R3: select must fall while convert is held high.
  assert_sel_fall_in_conv_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selReg) |-> convReg);

  // R4: convert stays high whenever the readout engine is running.
  assert_conv_high_reading_R4: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.runSck |-> (convReg && !selReg));

  // R9: an error is raised only together with dropping convert.
  assert_err_drops_conv_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errReg) |-> (!convReg && !busyOut));

  // R10: select only rises from the idle phase.
  assert_start_only_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selReg) |-> ($past(state) == S_IDLE));

endmodule

// File: rtl/adc_busy_datapath.sv
`timescale 1ns/1ps
module adc_busy_datapath
  import adc_busy_pkg::*;
#(
  parameter int WORD_BITS   = 18,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtrl_t              dpCtl,
  input  logic [DIV_W-1:0]     clkDivHalf,
  input  logic                 sdoIn,
  output logic                 sdoLow,
  output logic                 readDone,
  output logic                 sckOut,
  output logic [WORD_BITS-1:0] dataWord,
  output logic                 dataValid
);

  localparam int TOTAL   = WORD_BITS + 1;
  localparam int PULSE_W = $clog2(TOTAL + 1);

  logic [SYNC_STAGES-1:0] syncReg;
  logic [DIV_W-1:0]       divLimit;
  logic [DIV_W-1:0]       divCnt;
  logic                   sckReg;
  logic [PULSE_W-1:0]     pulseCnt;
  logic [WORD_BITS-1:0]   shiftReg;
  logic [WORD_BITS-1:0]   wordReg;
  logic                   doneReg;
  logic                   validReg;

  // Metastability filter for the busy indication; line idles high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '1;
    else       syncReg <= {syncReg[SYNC_STAGES-2:0], sdoIn};
  end
  assign sdoLow = ~syncReg[SYNC_STAGES-1];

  assign divLimit = (clkDivHalf == '0) ? DIV_W'(1) : clkDivHalf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      sckReg   <= 1'b0;
      pulseCnt <= '0;
      shiftReg <= '0;
      doneReg  <= 1'b0;
    end else if (dpCtl.clearRead) begin
      divCnt   <= '0;
      sckReg   <= 1'b0;
      pulseCnt <= '0;
      shiftReg <= '0;
      doneReg  <= 1'b0;
    end else if (dpCtl.runSck && !doneReg) begin
      if (divCnt == divLimit - DIV_W'(1)) begin
        divCnt <= '0;
        sckReg <= ~sckReg;
        if (!sckReg) begin
          // rising edge: the first one sees only the busy-low level
          pulseCnt <= pulseCnt + 1'b1;
          if (pulseCnt != '0) shiftReg <= {shiftReg[WORD_BITS-2:0], sdoIn};
        end else if (pulseCnt == PULSE_W'(TOTAL)) begin
          doneReg <= 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg  <= '0;
      validReg <= 1'b0;
    end else begin
      validReg <= dpCtl.publish;
      if (dpCtl.publish) wordReg <= shiftReg;
    end
  end

  assign readDone  = doneReg;
  assign sckOut    = sckReg;
  assign dataWord  = wordReg;
  assign dataValid = validReg;

  // R6: clock idles low outside a readout.
  assert_sck_idle_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtl.runSck |-> !sckReg);

  // R6: never more pulses than one word plus the busy bit.
  assert_pulse_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PULSE_W'(TOTAL));

  // R8: valid lasts one cycle.
  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    validReg |=> !validReg);

  // R8: the output word only moves with the valid strobe.
  assert_word_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !validReg |-> $stable(wordReg));

endmodule

// File: rtl/adc_busy_reader.sv
`timescale 1ns/1ps
module adc_busy_reader
  import adc_busy_pkg::*;
#(
  parameter int WORD_BITS   = 18,
  parameter int DIV_W       = 8,
  parameter int TO_W        = 16,
  parameter int SEL_SETUP   = 2,
  parameter int SEL_HOLD    = 4,
  parameter int MIN_CONV    = 20,
  parameter int MAX_CONV    = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic [DIV_W-1:0]     clkDivHalf,
  input  logic [TO_W-1:0]      timeoutLimit,
  input  logic                 sdoIn,
  output logic                 convOut,
  output logic                 selOut,
  output logic                 sckOut,
  output logic [WORD_BITS-1:0] dataWord,
  output logic                 dataValid,
  output logic                 busy,
  output logic                 timeoutErr
);

  dpCtrl_t dpCtl;
  logic    sdoLow;
  logic    readDone;

  adc_busy_ctrl #(
    .TO_W      (TO_W),
    .SEL_SETUP (SEL_SETUP),
    .SEL_HOLD  (SEL_HOLD),
    .MIN_CONV  (MIN_CONV),
    .MAX_CONV  (MAX_CONV)
  ) ctrlInst (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .timeoutLimit (timeoutLimit),
    .sdoLow       (sdoLow),
    .readDone     (readDone),
    .convOut      (convOut),
    .selOut       (selOut),
    .busyOut      (busy),
    .timeoutErr   (timeoutErr),
    .dpCtl        (dpCtl)
  );

  adc_busy_datapath #(
    .WORD_BITS   (WORD_BITS),
    .DIV_W       (DIV_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) dpInst (
    .clk        (clk),
    .rstN       (rstN),
    .dpCtl      (dpCtl),
    .clkDivHalf (clkDivHalf),
    .sdoIn      (sdoIn),
    .sdoLow     (sdoLow),
    .readDone   (readDone),
    .sckOut     (sckOut),
    .dataWord   (dataWord),
    .dataValid  (dataValid)
  );

endmodule

// File: tb/adc_busy_reader_test.sv
`timescale 1ns/1ps
module adc_busy_reader_test;

  localparam int CLK_PERIOD = 10;
  localparam int WB        = 18;
  localparam int SEL_SETUP = 2;
  localparam int SEL_HOLD  = 4;
  localparam int MAX_CONV  = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [7:0] clkDivHalf = 8'd1;
  logic [15:0] timeoutLimit = 16'd100;
  logic sdoLine = 1'b1;
  logic convOut, selOut, sckOut, dataValid, busy, timeoutErr;
  logic [WB-1:0] dataWord;

  int checks = 0;
  int errors = 0;
  int sckRises = 0;
  int convRises = 0;
  longint lastRise = 0;
  longint prevRise = 0;
  logic [WB-1:0] modelWord = '0;
  int modelConvCycles = 30;
  bit respond = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_busy_reader #(
    .WORD_BITS(WB), .DIV_W(8), .TO_W(16), .SEL_SETUP(SEL_SETUP),
    .SEL_HOLD(SEL_HOLD), .MIN_CONV(20), .MAX_CONV(MAX_CONV), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .clkDivHalf(clkDivHalf),
    .timeoutLimit(timeoutLimit), .sdoIn(sdoLine), .convOut(convOut),
    .selOut(selOut), .sckOut(sckOut), .dataWord(dataWord),
    .dataValid(dataValid), .busy(busy), .timeoutErr(timeoutErr)
  );

  always @(posedge sckOut) begin
    sckRises++;
    prevRise = lastRise;
    lastRise = $time;
  end
  always @(posedge convOut) convRises++;

  // Converter model: busy low after a delay, then one bit per falling SCK edge.
  initial begin
    forever begin
      @(posedge convOut);
      if (respond) begin
        repeat (modelConvCycles) @(negedge clk);
        sdoLine = 1'b0;
        for (int k = 1; k <= WB + 1; k++) begin
          @(negedge sckOut);
          sdoLine = (k <= WB) ? modelWord[WB-k] : 1'b1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic waitValid(output bit found);
    found = 1'b0;
    for (int i = 0; i < 4000 && !found; i++) begin
      if (dataValid) found = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic testReset();
    chk(convOut == 0 && selOut == 0 && sckOut == 0, "R1", "lines after reset",
        {convOut, selOut, sckOut}, 0);
    chk(dataValid == 0 && busy == 0 && timeoutErr == 0, "R1", "flags after reset",
        {dataValid, busy, timeoutErr}, 0);
  endtask

  // Full readout with a given word and divider; checks data and framing.
  task automatic testReadout(input logic [WB-1:0] word, input logic [7:0] div);
    bit found;
    longint effDiv;
    effDiv = (div == 0) ? 1 : div;
    modelWord = word; clkDivHalf = div; respond = 1'b1; modelConvCycles = 30;
    sckRises = 0;
    pulseStart();
    waitValid(found);
    chk(found, "R8", "valid seen", found, 1);
    chk(dataWord == word, "R7", "captured word", dataWord, word);
    chk(convOut == 1, "R4", "convert high at valid", convOut, 1);
    chk(selOut == 0, "R3", "select low at valid", selOut, 0);
    chk(sckRises == WB + 1, "R6", "pulse count", sckRises, WB + 1);
    chk((lastRise - prevRise) / CLK_PERIOD == 2 * effDiv, "R6", "sck period",
        (lastRise - prevRise) / CLK_PERIOD, 2 * effDiv);
    @(negedge clk);
    chk(dataValid == 0, "R8", "valid one cycle", dataValid, 0);
    chk(convOut == 0 && busy == 0, "R4", "convert drops after valid",
        {convOut, busy}, 0);
    chk(sckOut == 0, "R6", "sck idles low", sckOut, 0);
    repeat (5) @(negedge clk);
    chk(dataWord == word, "R8", "word held", dataWord, word);
  endtask

  // Cycle-exact select/convert sequence, late busy release, start while busy.
  task automatic testSequence();
    bit found;
    modelWord = 18'h2A5C3; clkDivHalf = 8'd2; respond = 1'b1;
    modelConvCycles = 60; timeoutLimit = 16'd100;
    convRises = 0; sckRises = 0;
    pulseStart();
    for (int n = 0; n < 70; n++) begin
      if (n == 0) begin
        chk(selOut == 1 && convOut == 0, "R2", "select first",
            {selOut, convOut}, 2'b10);
        chk(busy == 1, "R10", "busy after start", busy, 1);
      end
      if (n == SEL_SETUP - 1) chk(convOut == 0, "R2", "convert not yet", convOut, 0);
      if (n == SEL_SETUP) chk(convOut == 1 && selOut == 1, "R2", "convert with select",
                               {convOut, selOut}, 2'b11);
      if (n == SEL_SETUP + SEL_HOLD - 1) chk(selOut == 1, "R3", "select held", selOut, 1);
      if (n == SEL_SETUP + SEL_HOLD) chk(selOut == 0, "R3", "select dropped", selOut, 0);
      if (n == 40) startReq = 1'b1;
      if (n == 41) startReq = 1'b0;
      if (n == SEL_SETUP + 55) chk(sckRises == 0 && sckOut == 0, "R5",
                                   "no clock before busy low", sckRises, 0);
      @(negedge clk);
    end
    waitValid(found);
    chk(found && dataWord == 18'h2A5C3, "R7", "word after late release",
        dataWord, 18'h2A5C3);
    chk(convRises == 1, "R10", "start ignored while busy", convRises, 1);
    repeat (3) @(negedge clk);
    chk(convRises == 1 && busy == 0, "R10", "no second conversion",
        {convRises, busy}, 1);
  endtask

  // Converter never answers.
  task automatic testTimeout(input logic [WB-1:0] prevWord);
    bit sawValid;
    respond = 1'b0; timeoutLimit = 16'd10; sckRises = 0; sawValid = 1'b0;
    pulseStart();
    for (int n = 0; n <= SEL_SETUP + MAX_CONV + 14; n++) begin
      if (dataValid) sawValid = 1'b1;
      if (n == SEL_SETUP + MAX_CONV + 10) chk(convOut == 1 && timeoutErr == 0, "R9",
          "before deadline", {convOut, timeoutErr}, 2'b10);
      if (n == SEL_SETUP + MAX_CONV + 11) chk(convOut == 0 && timeoutErr == 1 && busy == 0,
          "R9", "at deadline", {convOut, timeoutErr, busy}, 3'b010);
      @(negedge clk);
    end
    chk(!sawValid && sckRises == 0, "R9", "no readout on timeout",
        {sawValid, sckRises}, 0);
    chk(dataWord == prevWord, "R8", "word kept on timeout", dataWord, prevWord);
    respond = 1'b1; timeoutLimit = 16'd100;
    pulseStart();
    chk(timeoutErr == 0, "R9", "error cleared by start", timeoutErr, 1'b0);
    repeat (500) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReadout(18'h2A5C3, 8'd1);
    testReadout(18'h3FFFF, 8'd3);
    testReadout(18'h00001, 8'd0);
    testSequence();
    testTimeout(18'h2A5C3);
    testReadout(18'h15A5A, 8'd2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule